// File: doc/BRIEF.md
# Network Status LED Mode Controller

This block drives one active-low status LED from a condition chosen out of the live link and MAC status. A 4-bit source code in a control word picks the condition: a link speed or a combination of speeds, link with or without traffic, full duplex, collision, single-lane bus width, transmit pause, or the constants on and off. The chosen condition can be gated by a symmetric blink at one of two rates. The result can then be inverted before it reaches the pin.

Software or a loader writes the control word through a simple write strobe and reads it back from a read bus. A millisecond tick, derived from the clock frequency parameter, paces the blink. The blink phase restarts on a write that changes the blink enable or the blink rate bit.

Top module: `netled_ctrl`

## Requirements
- R1: After reset the control word reads 0x0006_0000 (source code 0110, blink rate, invert and blink enable all 0), and `led_n` is 1 while the link is down.
- R2: Control word layout: source code in bits 19:16, blink rate bit 21, invert bit 22, blink enable bit 23. Bits 31:24, 20 and 15:0 are ignored on write and read as 0.
- R3: Source codes 0000, 0001 and 0010 light the LED when the link is up at 10 or 1000 Mb/s, at 100 or 1000 Mb/s, and at any speed. Speed encoding on `link_speed`: 00 = 10, 01 = 100, 10 = 1000, 11 = none.
- R4: Code 0011 lights when the link is up and `filt_active` is 1. Code 0100 lights when the link is up and `trx_active` is 0.
- R5: Codes 0101, 0110 and 0111 light for a link that is up at 10, 100 and 1000 Mb/s.
- R6: Code 1001 lights for a link that is up and `full_duplex` is 1. Code 1010 lights whenever `collision` is 1. Code 1011 lights when the link is up and `trx_active` is 1.
- R7: Code 1100 follows `one_lane` and code 1101 follows `tx_paused`. Code 1110 is always lit. Codes 1111 and the reserved 1000 are always dark.
- R8: `led_n` is active low (lit = 0) and registered. It reflects the inputs and the control word present before the previous rising clock edge.
- R9: Invert is applied after the blink gate. With invert set, the pin shows the complement of the gated condition.
- R10: With blink enabled and rate bit 0, the gate is on for 200 ms and then off for 200 ms, repeating. After a write that changes the blink enable or rate bit, the on phase starts.
- R11: With blink enabled and rate bit 1, the gate alternates on and off every 83 ms, with the same restart rule.
- R12: While blinking, the LED is lit only when the condition is true and the gate is in its on phase. A false condition stays dark through both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 00 = 10, 01 = 100, 10 = 1000 Mb/s, 11 = none |
| full_duplex | input | 1 | Link runs full duplex |
| collision | input | 1 | Collision observed |
| trx_active | input | 1 | Any transmit or receive activity |
| filt_active | input | 1 | Activity on frames that passed filtering |
| one_lane | input | 1 | Single-lane bus connection detected |
| tx_paused | input | 1 | Transmitter held by flow control |
| led_n | output | 1 | LED pin, active low |

## Verification
Every source code is swept with both invert settings against all 512 combinations of the status inputs. All four speed encodings are covered, with and without link. This separates each code's condition from its neighbours and shows that the link qualifier is present or absent where intended. The blink runs on an always-on source at each rate and is checked sample by sample against the expected on/off boundaries after restart. An always-off source is blinked with and without invert, which shows that gating comes before inversion. Control writes carry ones in every reserved bit so that the readback shows they were dropped.

// File: rtl/led_pkg.sv
package led_pkg;
   typedef enum logic [3:0] {
      SRC_L10_1G  = 4'h0,
      SRC_L100_1G = 4'h1,
      SRC_LINK    = 4'h2,
      SRC_FACT    = 4'h3,
      SRC_IDLE    = 4'h4,
      SRC_S10     = 4'h5,
      SRC_S100    = 4'h6,
      SRC_S1G     = 4'h7,
      SRC_RSVD    = 4'h8,
      SRC_FDX     = 4'h9,
      SRC_COL     = 4'hA,
      SRC_ACT     = 4'hB,
      SRC_LANE1   = 4'hC,
      SRC_PAUSE   = 4'hD,
      SRC_ON      = 4'hE,
      SRC_OFF     = 4'hF
   } led_src_e;

   typedef struct packed {
      logic     blink_en;
      logic     invert;
      logic     fast;
      led_src_e src;
   } led_cfg_t;

   typedef struct packed {
      logic       link_up;
      logic [1:0] speed;
      logic       fdx;
      logic       col;
      logic       act;
      logic       fact;
      logic       lane1;
      logic       paused;
   } led_stat_t;

   localparam int SRC_LSB   = 16;
   localparam int FAST_BIT  = 21;
   localparam int INV_BIT   = 22;
   localparam int BLINK_BIT = 23;
endpackage

// File: rtl/led_ctrl_reg.sv
module led_ctrl_reg
   import led_pkg::*;
#(
   parameter int       DW      = 32,
   parameter led_src_e RST_SRC = SRC_S100
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output led_cfg_t      cfg,
   output logic          restart
);
   led_cfg_t nxt;

   always_comb begin
      nxt.src      = led_src_e'(wr_data[SRC_LSB +: 4]);
      nxt.fast     = wr_data[FAST_BIT];
      nxt.invert   = wr_data[INV_BIT];
      nxt.blink_en = wr_data[BLINK_BIT];
   end

   assign restart = wr_en && ((nxt.fast != cfg.fast) || (nxt.blink_en != cfg.blink_en));

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg.src      <= RST_SRC;
         cfg.fast     <= 1'b0;
         cfg.invert   <= 1'b0;
         cfg.blink_en <= 1'b0;
      end else if (wr_en) begin
         cfg <= nxt;
      end
   end

   always_comb begin
      rd_data                 = '0;
      rd_data[SRC_LSB +: 4]   = cfg.src;
      rd_data[FAST_BIT]       = cfg.fast;
      rd_data[INV_BIT]        = cfg.invert;
      rd_data[BLINK_BIT]      = cfg.blink_en;
   end
endmodule

// File: rtl/led_src_sel.sv
module led_src_sel
   import led_pkg::*;
(
   input  led_src_e  src,
   input  led_stat_t st,
   output logic      cond
);
   logic up10, up100, up1g;

   always_comb begin
      up10  = st.link_up && (st.speed == 2'b00);
      up100 = st.link_up && (st.speed == 2'b01);
      up1g  = st.link_up && (st.speed == 2'b10);
      unique case (src)
         SRC_L10_1G:  cond = up10 || up1g;
         SRC_L100_1G: cond = up100 || up1g;
         SRC_LINK:    cond = st.link_up;
         SRC_FACT:    cond = st.link_up && st.fact;
         SRC_IDLE:    cond = st.link_up && !st.act;
         SRC_S10:     cond = up10;
         SRC_S100:    cond = up100;
         SRC_S1G:     cond = up1g;
         SRC_RSVD:    cond = 1'b0;
         SRC_FDX:     cond = st.link_up && st.fdx;
         SRC_COL:     cond = st.col;
         SRC_ACT:     cond = st.link_up && st.act;
         SRC_LANE1:   cond = st.lane1;
         SRC_PAUSE:   cond = st.paused;
         SRC_ON:      cond = 1'b1;
         SRC_OFF:     cond = 1'b0;
         default:     cond = 1'b0;
      endcase
   end
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
   parameter int CLK_HZ  = 125_000_000,
   parameter int SLOW_MS = 200,
   parameter int FAST_MS = 83
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic fast,
   output logic phase_on
);
   localparam int DIV   = CLK_HZ / 1000;
   localparam int MAXMS = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
   localparam int CW    = $clog2(MAXMS + 1);

   logic          ms_tick;
   logic [CW-1:0] ms_cnt;
   logic [CW-1:0] half_lim;

   generate
      if (DIV == 1) begin : g_nodiv
         assign ms_tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] presc;
         assign ms_tick = (presc == PW'(DIV - 1));
         always_ff @(posedge clk) begin
            if (rst || restart || ms_tick) presc <= '0;
            else                           presc <= presc + 1'b1;
         end
      end
   endgenerate

   assign half_lim = fast ? CW'(FAST_MS - 1) : CW'(SLOW_MS - 1);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         ms_cnt   <= '0;
         phase_on <= 1'b1;
      end else if (ms_tick) begin
         if (ms_cnt >= half_lim) begin
            ms_cnt   <= '0;
            phase_on <= !phase_on;
         end else begin
            ms_cnt <= ms_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/netled_ctrl.sv
module netled_ctrl
   import led_pkg::*;
#(
   parameter int CLK_HZ  = 125_000_000,
   parameter int SLOW_MS = 200,
   parameter int FAST_MS = 83,
   parameter int DW      = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic          link_up,
   input  logic [1:0]    link_speed,
   input  logic          full_duplex,
   input  logic          collision,
   input  logic          trx_active,
   input  logic          filt_active,
   input  logic          one_lane,
   input  logic          tx_paused,
   output logic          led_n
);
   generate
      if (CLK_HZ < 1000 || (CLK_HZ % 1000) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a positive multiple of 1000");
      end
      if (DW < 32) begin : g_bad_dw
         $error("DW must be at least 32");
      end
      if (SLOW_MS < 1 || FAST_MS < 1) begin : g_bad_ms
         $error("blink half periods must be at least 1 ms");
      end
   endgenerate

   led_cfg_t  cfg;
   led_stat_t st;
   logic      restart, cond, phase_on, lit;

   led_ctrl_reg #(.DW(DW), .RST_SRC(SRC_S100)) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cfg(cfg), .restart(restart)
   );

   assign st = '{link_up: link_up, speed: link_speed, fdx: full_duplex,
                 col: collision, act: trx_active, fact: filt_active,
                 lane1: one_lane, paused: tx_paused};

   led_src_sel u_sel (.src(cfg.src), .st(st), .cond(cond));

   led_blink_gen #(.CLK_HZ(CLK_HZ), .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS)) u_blink (
      .clk(clk), .rst(rst), .restart(restart), .fast(cfg.fast), .phase_on(phase_on)
   );

   assign lit = (cond && (!cfg.blink_en || phase_on)) ^ cfg.invert;

   always_ff @(posedge clk) begin
      if (rst) led_n <= 1'b1;
      else     led_n <= !lit;
   end
endmodule

// File: rtl/netled_ctrl_chk.sv
module netled_ctrl_chk (
   input logic        clk,
   input logic        rst,
   input logic [31:0] rd_data,
   input logic        led_n
);
   // R2: reserved readback bits stay zero
   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (rd_data & 32'hFF10_FFFF) == 32'h0);

   // R1: first cycle out of reset shows the default control word
   assert_reset_word_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> rd_data == 32'h0006_0000);

   // R7: constant-on source, no blink, no invert, lights next cycle
   assert_const_on_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_data[19:16] == 4'hE && rd_data[23:22] == 2'b00) |=> !led_n);

   // R7: constant-off and reserved sources stay dark without invert
   assert_const_off_R7: assert property (@(posedge clk) disable iff (rst)
      ((rd_data[19:16] == 4'hF || rd_data[19:16] == 4'h8) && !rd_data[22]) |=> led_n);

   // R9: inverted false condition is lit whatever the blink phase
   assert_inv_after_gate_R9: assert property (@(posedge clk) disable iff (rst)
      (rd_data[19:16] == 4'hF && rd_data[22]) |=> !led_n);
endmodule

bind netled_ctrl netled_ctrl_chk u_chk (
   .clk(clk), .rst(rst), .rd_data(rd_data), .led_n(led_n)
);

// File: tb/netled_ctrl_test.sv
module netled_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int TB_HZ      = 2000;
   localparam int DIVC       = TB_HZ / 1000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        link_up = 0, full_duplex = 0, collision = 0;
   logic        trx_active = 0, filt_active = 0, one_lane = 0, tx_paused = 0;
   logic [1:0]  link_speed = 2'b00;
   logic        led_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   netled_ctrl #(.CLK_HZ(TB_HZ)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .link_up(link_up), .link_speed(link_speed), .full_duplex(full_duplex),
      .collision(collision), .trx_active(trx_active), .filt_active(filt_active),
      .one_lane(one_lane), .tx_paused(tx_paused), .led_n(led_n)
   );

   function automatic string tag_of(input int m);
      case (m)
         0, 1, 2:    return "R3";
         3, 4:       return "R4";
         5, 6, 7:    return "R5";
         9, 10, 11:  return "R6";
         default:    return "R7";
      endcase
   endfunction

   function automatic bit model(input int m, input int c);
      bit up, fd, col, act, fa, ln, pz;
      int sp, mb;
      up = c[0]; sp = (c >> 1) & 3; fd = c[3]; col = c[4];
      act = c[5]; fa = c[6]; ln = c[7]; pz = c[8];
      mb = up ? (sp == 0 ? 10 : sp == 1 ? 100 : sp == 2 ? 1000 : 0) : 0;
      case (m)
         0:  return (mb == 10) || (mb == 1000);
         1:  return (mb == 100) || (mb == 1000);
         2:  return up;
         3:  return up && fa;
         4:  return up && !act;
         5:  return mb == 10;
         6:  return mb == 100;
         7:  return mb == 1000;
         9:  return up && fd;
         10: return col;
         11: return up && act;
         12: return ln;
         13: return pz;
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic write_cfg(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic blink_window(input string req, input int half_ms, input int n, input bit on_means_lit);
      for (int k = 1; k <= n; k++) begin
         bit ph;
         @(posedge clk);
         @(negedge clk);
         ph = (((k - 1) / (DIVC * half_ms)) % 2) == 0;
         check(req, {31'b0, led_n}, {31'b0, !(on_means_lit ? ph : !ph)});
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", rd_data, 32'h0006_0000);
      check("R1", {31'b0, led_n}, 32'h1);
      rst = 1'b0;
      @(negedge clk);
      check("R1", rd_data, 32'h0006_0000);

      // source sweep: every code, both invert settings, all status patterns
      for (int m = 0; m < 16; m++) begin
         for (int inv = 0; inv < 2; inv++) begin
            logic [31:0] fields;
            fields = (32'(m) << 16) | (32'(inv) << 22);
            write_cfg(fields | 32'hFF10_FFFF);
            check("R2", rd_data, fields);
            for (int c = 0; c < 512; c++) begin
               bit lit;
               link_up = c[0]; link_speed = 2'((c >> 1) & 3); full_duplex = c[3];
               collision = c[4]; trx_active = c[5]; filt_active = c[6];
               one_lane = c[7]; tx_paused = c[8];
               @(posedge clk);
               @(negedge clk);
               lit = model(m, c) ^ inv[0];
               // R8: active-low pin, one register stage
               check(tag_of(m), {31'b0, led_n}, {31'b0, !lit});
            end
         end
      end

      // R10: slow blink on constant-on source
      write_cfg(32'h000E_0000);
      write_cfg(32'h008E_0000);
      check("R2", rd_data, 32'h008E_0000);
      blink_window("R10", 200, 1000, 1'b1);

      // R11: switch rate restarts with on phase
      write_cfg(32'h00AE_0000);
      blink_window("R11", 83, 500, 1'b1);

      // R12: false condition stays dark through blinking
      write_cfg(32'h000F_0000);
      write_cfg(32'h008F_0000);
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         check("R12", {31'b0, led_n}, 32'h1);
      end

      // R9: invert after gate, false condition inverted is always lit
      write_cfg(32'h000F_0000);
      write_cfg(32'h00CF_0000);
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         check("R9", {31'b0, led_n}, 32'h0);
      end

      // R9: inverted blinking of constant-on source follows the off phase
      write_cfg(32'h004E_0000);
      write_cfg(32'h00CE_0000);
      blink_window("R9", 200, 900, 1'b0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule